// File: doc/BRIEF.md
# Serial EEPROM Command Controller

This block is the command engine on the slave side of a 512-byte serial EEPROM reached over an SPI link in mode 0 or mode 3. A separate front end samples the serial input on each rising clock edge and hands the block one bit per strobe. The front end also drives the serial output from `out_bit` on the following falling edge, and only while `out_en` is high. The controller decodes the command byte and gathers the address. It streams array bytes or the status byte, fills a 16-byte page latch for writes, and hands the latched data to a behavioural array once a timed write cycle ends.

Write permission comes from a neighbouring protection block. That block looks at `wel`, `blk_prot` and `wr_page`, and answers on `wr_allow`. The internal programming time is modelled by a counter whose length, `WCYC`, is given in clock cycles.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset `out_en`, `busy` and `wel` are 0 and `blk_prot` is 00.
- R2: A command byte of the form 0000_h011 selects a read. Its bit 3 (h) is address bit 8, and the next byte carries address bits 7..0. All bytes travel MSB first. The first data bit is on `out_bit`, with `out_en` high, right after the strobe that carries address bit 0.
- R3: A read goes on for as long as strobes arrive. The address advances by one per byte and wraps from 0x1FF to 0x000.
- R4: The command 0x06 sets `wel`, and 0x04 clears it. Either one takes effect only when chip select rises straight after the eighth bit. Any further bit cancels it.
- R5: A write command (0000_h010) is followed by an address byte and then data bytes, which go into consecutive page slots. The slot index is address bits 3..0. It wraps from 15 to 0 inside the page, so a later byte replaces an earlier one in the same slot.
- R6: A write cycle starts only if all of these hold when chip select rises: at least one whole data byte was received, no partial byte is pending, `wel` is 1 and `wr_allow` is 1. Otherwise `busy` stays low and the array is unchanged.
- R7: Only the slots that received data are written. The other bytes of the page keep their contents.
- R8: `busy` is high for exactly `WCYC` cycles, starting at the edge that sees chip select rise. `wel` is 0 once `busy` falls.
- R9: While `busy` is high, read, write, status-write and latch commands have no effect, and a read drives nothing. The status read 0x05 still works. It repeats the byte {0000, blk_prot[1:0], wel, busy}, with busy in bit 0, re-sampled for each byte.
- R10: The command 0x01 followed by a byte runs a timed cycle under the same rules as R6. At its end, byte bits 3..2 go to `blk_prot`.
- R11: Any other command byte leaves `out_en` low and changes nothing until chip select rises.
- R12: After the address byte of a write, `wr_page` shows address bits 8..4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Synchronised chip select, low when selected |
| bit_valid | input | 1 | One-cycle strobe for a sampled serial bit |
| bit_in | input | 1 | Serial bit that goes with the strobe |
| wr_allow | input | 1 | Permission from the protection block for the pending commit |
| out_bit | output | 1 | Bit for the front end to drive on the serial output |
| out_en | output | 1 | Serial output is driven |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Write cycle in progress |
| blk_prot | output | 2 | Block-protect field held by the status register |
| wr_page | output | 5 | Page number of the pending write |

## Verification
Every page is filled with its own arithmetic pattern. The whole array is then read back in one pass that starts near the top, which separates address advance and wrap errors from data errors. Partial page writes, a write that runs past the end of its page, and commits cut short at several bit positions or without permission show whether the byte mask, the slot wrap and the commit gate each work on their own. Commands issued during a write cycle, together with the status reads in that window, separate the busy gating from the timer length.

// File: rtl/eepc_pkg.sv
package eepc_pkg;
  localparam int ADDR_W = 9;  // fixed by command format: 1 bit in opcode + 1 address byte

  typedef enum logic [2:0] {PH_CMD, PH_ADR, PH_WDAT, PH_OUT, PH_ARM, PH_IGN} phase_t;
  typedef enum logic [2:0] {OP_NONE, OP_READ, OP_WRITE, OP_RDSR, OP_WRSR, OP_WREN, OP_WRDI} op_t;

  function automatic op_t decode_op(input logic [7:0] b);
    if (b[7:4] != 4'h0) return OP_NONE;
    if (b[2:0] == 3'b011) return OP_READ;
    if (b[2:0] == 3'b010) return OP_WRITE;
    case (b[3:0])
      4'h6: return OP_WREN;
      4'h4: return OP_WRDI;
      4'h5: return OP_RDSR;
      4'h1: return OP_WRSR;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic [7:0] status_byte(input logic [1:0] bp, input logic we, input logic bz);
    return {4'b0000, bp, we, bz};
  endfunction
endpackage

// File: rtl/eepc_bytecol.sv
module eepc_bytecol (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       bit_valid,
  input  logic       bit_in,
  output logic [2:0] bit_idx,
  output logic       byte_done,
  output logic [7:0] byte_val
);
  logic [6:0] sh;

  assign byte_done = bit_valid && !cs_n && (bit_idx == 3'd7);
  assign byte_val  = {sh, bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx <= '0;
      sh      <= '0;
    end else if (cs_n) begin
      bit_idx <= '0;
    end else if (bit_valid) begin
      sh      <= {sh[5:0], bit_in};
      bit_idx <= bit_idx + 3'd1;
    end
  end
endmodule

// File: rtl/eepc_wtimer.sv
module eepc_wtimer #(
  parameter int WCYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(WCYC + 1);
  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= CW'(WCYC);
    else if (busy)   cnt <= cnt - CW'(1);
  end

  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n) start |-> !busy); // R8
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy); // R8
endmodule

// File: rtl/eepc_store.sv
module eepc_store #(
  parameter int ADDR_W = 9,
  parameter int COL_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [7:0]              rd_data,
  input  logic                    lat_clr,
  input  logic                    lat_we,
  input  logic [COL_W-1:0]        lat_col,
  input  logic [7:0]              lat_data,
  input  logic [ADDR_W-COL_W-1:0] lat_page,
  input  logic                    commit
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SLOTS = 1 << COL_W;

  logic [7:0]       mem [DEPTH];
  logic [7:0]       lat [SLOTS];
  logic [SLOTS-1:0] vld;

  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       vld <= '0;
    else if (lat_clr) vld <= '0;
    else if (lat_we)  vld[lat_col] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (lat_we) lat[lat_col] <= lat_data;
  end

  // only slots that received data reach the array
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (vld[i]) mem[{lat_page, COL_W'(i)}] <= lat[i];
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import eepc_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int WCYC  = 1000,
  localparam int PG_W = ADDR_W - COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            bit_valid,
  input  logic            bit_in,
  input  logic            wr_allow,
  output logic            out_bit,
  output logic            out_en,
  output logic            wel,
  output logic            busy,
  output logic [1:0]      blk_prot,
  output logic [PG_W-1:0] wr_page
);
  phase_t             phase;
  op_t                op;
  logic               a8;
  logic [ADDR_W-1:0]  ptr;
  logic [COL_W-1:0]   col;
  logic               got;
  logic [7:0]         out_sh;
  logic [1:0]         sr_bp;
  logic               sr_cycle;
  logic               cs_q;

  logic [2:0]         bit_idx;
  logic               byte_done;
  logic [7:0]         byte_val;
  logic [7:0]         rd_data;
  logic               done;

  // named internal events
  op_t                dec;
  logic [ADDR_W-1:0]  rd_addr;
  logic               cs_rise;
  logic               at_bound;
  logic               wr_start;
  logic               lat_we;
  logic               lat_clr;
  logic               rd_reload;
  logic               latch_go;

  assign dec       = decode_op(byte_val);
  assign rd_addr   = (phase == PH_ADR) ? {a8, byte_val} : ptr;
  assign cs_rise   = cs_n && !cs_q;
  assign at_bound  = (bit_idx == 3'd0);
  assign wr_start  = cs_rise && (phase == PH_WDAT) && at_bound && got && wel && wr_allow;
  assign latch_go  = cs_rise && (phase == PH_ARM) && at_bound;
  assign lat_we    = byte_done && (phase == PH_WDAT) && (op == OP_WRITE);
  assign lat_clr   = byte_done && (phase == PH_ADR) && (op == OP_WRITE);
  assign rd_reload = byte_done && (phase == PH_OUT) && (op == OP_READ);
  assign out_bit   = out_sh[7];
  assign out_en    = (phase == PH_OUT) && !cs_n;

  eepc_bytecol u_bytecol (
    .clk, .rst_n, .cs_n, .bit_valid, .bit_in,
    .bit_idx, .byte_done, .byte_val
  );

  eepc_wtimer #(.WCYC(WCYC)) u_wtimer (
    .clk, .rst_n, .start(wr_start), .busy, .done
  );

  eepc_store #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_store (
    .clk, .rst_n, .rd_addr, .rd_data,
    .lat_clr, .lat_we, .lat_col(col), .lat_data(byte_val),
    .lat_page(wr_page), .commit(done && !sr_cycle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_CMD;
      op       <= OP_NONE;
      a8       <= 1'b0;
      ptr      <= '0;
      col      <= '0;
      got      <= 1'b0;
      out_sh   <= '0;
      sr_bp    <= '0;
      sr_cycle <= 1'b0;
      cs_q     <= 1'b1;
      wel      <= 1'b0;
      blk_prot <= '0;
      wr_page  <= '0;
    end else begin
      cs_q <= cs_n;
      if (latch_go)  wel <= (op == OP_WREN);
      else if (done) wel <= 1'b0;
      if (wr_start) sr_cycle <= (op == OP_WRSR);
      if (done && sr_cycle) blk_prot <= sr_bp;

      if (cs_n) begin
        phase <= PH_CMD;
      end else if (bit_valid) begin
        if (phase == PH_OUT) begin
          if (!byte_done)          out_sh <= {out_sh[6:0], 1'b0};
          else if (op == OP_READ) begin
            out_sh <= rd_data;
            ptr    <= ptr + ADDR_W'(1);
          end else                 out_sh <= status_byte(blk_prot, wel, busy);
        end
        if (byte_done) begin
          case (phase)
            PH_CMD: begin
              op  <= dec;
              a8  <= byte_val[3];
              got <= 1'b0;
              case (dec)
                OP_READ, OP_WRITE:  phase <= busy ? PH_IGN : PH_ADR;
                OP_WRSR:            phase <= busy ? PH_IGN : PH_WDAT;
                OP_WREN, OP_WRDI:   phase <= busy ? PH_IGN : PH_ARM;
                OP_RDSR: begin
                  phase  <= PH_OUT;
                  out_sh <= status_byte(blk_prot, wel, busy);
                end
                default:            phase <= PH_IGN;
              endcase
            end
            PH_ADR: begin
              if (op == OP_READ) begin
                out_sh <= rd_data;
                ptr    <= rd_addr + ADDR_W'(1);
                phase  <= PH_OUT;
              end else begin
                col     <= rd_addr[COL_W-1:0];
                wr_page <= rd_addr[ADDR_W-1:COL_W];
                phase   <= PH_WDAT;
              end
            end
            PH_WDAT: begin
              got <= 1'b1;
              if (op == OP_WRSR) sr_bp <= byte_val[3:2];
              else               col   <= col + COL_W'(1);
            end
            PH_ARM:  phase <= PH_IGN;
            default: ;
          endcase
        end
      end
    end
  end

  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n) done |=> !wel); // R8
  AST_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_OUT && op == OP_READ) |-> !busy); // R9
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (rd_reload && ptr == '1) |=> (ptr == '0)); // R3
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (lat_we && col == '1) |=> (col == '0)); // R5
  AST_NO_OUT_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n) (byte_done && phase == PH_CMD && dec == OP_NONE) |=> !out_en); // R11
endmodule

// File: tb/test_spi_eeprom_ctrl.sv
module test_spi_eeprom_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic wr_allow = 1'b1;
  logic out_bit, out_en, wel, busy;
  logic [1:0] blk_prot;
  logic [4:0] wr_page;

  int total = 0;
  int bad = 0;
  logic [7:0] model [0:511];

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_eeprom_ctrl #(.COL_W(4), .WCYC(TW)) i_spi_eeprom_ctrl (
    .clk, .rst_n, .cs_n, .bit_valid, .bit_in, .wr_allow,
    .out_bit, .out_en, .wel, .busy, .blk_prot, .wr_page
  );

  function automatic logic [7:0] pat(input int a, input int s);
    return 8'((a * 37 + s * 101 + (a >> 4) * 3) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b;
    bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic recv_byte(output logic [7:0] r, output bit en);
    en = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      r[i] = out_bit;
      if (!out_en) en = 1'b0;
      send_bit(1'b0);
    end
  endtask

  task automatic cs_on();
    @(negedge clk);
    cs_n = 1'b0;
  endtask

  task automatic cs_off();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic one_cmd(input logic [7:0] c);
    cs_on();
    send_byte(c);
    cs_off();
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input int addr, input int n, input int s, input bit upd);
    logic [8:0] a;
    a = 9'(addr);
    cs_on();
    send_byte({4'b0000, a[8], 3'b010});
    send_byte(a[7:0]);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = pat(addr + k, s);
      send_byte(d);
      if (upd) model[(addr & 'h1F0) | ((addr + k) & 'hF)] = d;
    end
    cs_off();
  endtask

  task automatic do_read(input int addr, input int n, input string tag);
    logic [8:0] a;
    logic [7:0] r;
    bit en;
    a = 9'(addr);
    cs_on();
    send_byte({4'b0000, a[8], 3'b011});
    send_byte(a[7:0]);
    for (int k = 0; k < n; k++) begin
      int idx;
      idx = (addr + k) % 512;
      recv_byte(r, en);
      chk(en && r === model[idx], tag, int'(r), int'(model[idx]));
    end
    cs_off();
  endtask

  task automatic read_status(input logic [7:0] exp, input string tag);
    logic [7:0] r;
    bit en;
    cs_on();
    send_byte(8'h05);
    for (int k = 0; k < 2; k++) begin
      recv_byte(r, en);
      chk(en && r === exp, tag, int'(r), int'(exp));
    end
    cs_off();
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [7:0] r;
    bit en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_en === 1'b0, "R1 out_en", int'(out_en), 0);
    chk(busy === 1'b0, "R1 busy", int'(busy), 0);
    chk(wel === 1'b0, "R1 wel", int'(wel), 0);
    chk(blk_prot === 2'b00, "R1 blk_prot", int'(blk_prot), 0);

    // R4 latch set / clear / cancelled by extra bit
    one_cmd(8'h06);
    chk(wel === 1'b1, "R4 set", int'(wel), 1);
    one_cmd(8'h04);
    chk(wel === 1'b0, "R4 clear", int'(wel), 0);
    cs_on(); send_byte(8'h06); send_bit(1'b0); cs_off();
    chk(wel === 1'b0, "R4 extra bit", int'(wel), 0);

    // R11 unknown opcode: no output, no effect
    one_cmd(8'h06);
    cs_on();
    send_byte(8'h07);
    chk(out_en === 1'b0, "R11 out_en after op", int'(out_en), 0);
    send_byte(8'h06);
    chk(out_en === 1'b0, "R11 out_en later", int'(out_en), 0);
    cs_off();
    chk(wel === 1'b1 && busy === 1'b0, "R11 state", int'({wel, busy}), 2);

    // fill all pages; exact busy window on the first one (R8)
    for (int p = 0; p < 32; p++) begin
      if (p != 0) one_cmd(8'h06);
      do_write(p * 16, 16, 1, 1'b1);
      if (p == 0) begin
        chk(busy === 1'b1, "R8 busy at start", int'(busy), 1);
        repeat (TW - 1) @(negedge clk);
        chk(busy === 1'b1, "R8 busy last cycle", int'(busy), 1);
        @(negedge clk);
        chk(busy === 1'b0, "R8 busy end", int'(busy), 0);
        chk(wel === 1'b0, "R8 wel cleared", int'(wel), 0);
      end
      wait_idle();
    end

    // R2 single read with address bit 8 set; R3 full sweep across the wrap
    do_read('h1A7, 1, "R2 read");
    do_read('h1F8, 528, "R3 sweep");

    // R5 in-page wrap with overwrite
    one_cmd(8'h06);
    do_write('h0AE, 18, 2, 1'b1);
    wait_idle();
    do_read('h0A0, 16, "R5 page wrap");

    // R7 partial page keeps the rest
    one_cmd(8'h06);
    do_write('h135, 2, 3, 1'b1);
    wait_idle();
    do_read('h130, 16, "R7 partial");

    // R6 commit gating
    one_cmd(8'h06);
    cs_on(); send_byte(8'h02); send_byte(8'h40); send_byte(8'hEE);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); cs_off();
    chk(busy === 1'b0, "R6 partial byte", int'(busy), 0);
    cs_on(); send_byte(8'h02); send_byte(8'h41); cs_off();
    chk(busy === 1'b0, "R6 no data", int'(busy), 0);
    wr_allow = 1'b0;
    do_write('h042, 2, 5, 1'b0);
    chk(busy === 1'b0, "R6 not allowed", int'(busy), 0);
    wr_allow = 1'b1;
    chk(wel === 1'b1, "R6 wel kept", int'(wel), 1);
    one_cmd(8'h04);
    do_write('h043, 2, 6, 1'b0);
    chk(busy === 1'b0, "R6 no wel", int'(busy), 0);
    do_read('h040, 16, "R6 array kept");

    // R9 behaviour during a write cycle
    one_cmd(8'h06);
    do_write('h050, 1, 4, 1'b1);
    read_status(8'h03, "R9 status busy");
    cs_on(); send_byte(8'h03); send_byte(8'h50);
    chk(out_en === 1'b0, "R9 read ignored", int'(out_en), 0);
    cs_off();
    do_write('h060, 1, 7, 1'b0);
    wait_idle();
    chk(wel === 1'b0, "R8 wel after cycle", int'(wel), 0);
    read_status(8'h00, "R9 status idle");
    do_read('h050, 1, "R9 committed byte");
    do_read('h060, 1, "R9 ignored write");

    // R10 status write
    one_cmd(8'h06);
    cs_on(); send_byte(8'h01); send_byte(8'h0C); cs_off();
    wait_idle();
    chk(blk_prot === 2'b11, "R10 bp set", int'(blk_prot), 3);
    read_status(8'h0C, "R10 status");
    cs_on(); send_byte(8'h01); send_byte(8'h00); cs_off();
    chk(busy === 1'b0 && blk_prot === 2'b11, "R10 no wel", int'({busy, blk_prot}), 3);
    one_cmd(8'h06);
    cs_on(); send_byte(8'h01); send_byte(8'h04); cs_off();
    wait_idle();
    chk(blk_prot === 2'b01, "R10 bp one", int'(blk_prot), 1);

    // R12 pending page number
    cs_on(); send_byte(8'h0A); send_byte(8'hC3);
    chk(wr_page === 5'h1C, "R12 page", int'(wr_page), 'h1C);
    cs_off();
    chk(busy === 1'b0, "R12 no commit", int'(busy), 0);

    finish_up();
  end
endmodule